// File: doc/BRIEF.md
# Dual-Channel Converter Bus Interface

This block sits between an 8-bit microprocessor bus and a two-channel analog I/O port. The host selects the block with an active-low chip select. It then uses an active-low write strobe either to load a DAC register or to start an analog-to-digital conversion. It uses an active-low read strobe to fetch the last conversion result. Two address lines choose the function and the channel. The function line `fn_dac` is 0 for the ADC and 1 for the DAC. The channel line `ch_b` is 0 for channel A and 1 for channel B. The bidirectional data bus is split into `bus_in`, `bus_out` and an output-enable `bus_oe`, so that the pad ring can build the tri-state driver.

Conversions are 8-bit successive approximation. The block drives the trial code to an external comparator DAC and reads back one comparator bit, `cmp_in`. `cmp_in` is 1 when the held input is at or above the trial code. It raises `hold` for the track-and-hold and presents the chosen input channel on `in_sel`. At the end of a conversion the result lands in an output latch and the active-low completion flag `int_n` falls. A DAC write with `xfer_adc` high copies that latch into the addressed DAC register, so the host does not need to send the byte again.

All three strobes are brought into the block clock with two-flip-flop synchronizers. Edges are taken on the synchronized copies, which adds two cycles of latency from a pin change to its effect. There is no streaming data path here, so every pin is a plain level signal.

Top module: `dual_conv_port`

## Requirements
- R1: While `cs_n` is high, pulses on `wr_n` and `rd_n` change no DAC register, start no conversion, and leave `bus_oe` at 0.
- R2: With `cs_n` low and `fn_dac`=0, a conversion starts on the rising edge of `wr_n`, not the falling edge. `hold` goes to 1 and `in_sel` takes the value of `ch_b` (0 = A, 1 = B).
- R3: With `cs_n` low, `fn_dac`=1 and `xfer_adc`=0, the rising edge of `wr_n` loads `bus_in` into DAC A when `ch_b`=0 and into DAC B when `ch_b`=1. The other register is unchanged.
- R4: The first trial code is 0x80. Every BIT_CYCLES clocks one bit is decided, MSB first: a `cmp_in` of 1 keeps that bit and the next lower bit is set for trial. The result therefore equals the input code of the held channel.
- R5: At the last decision, 3+8*BIT_CYCLES clocks after the `wr_n` rise, several things happen on the same edge. The result is copied into the output latch, `int_n` goes to 0, `hold` goes to 0 and `trial_code` is cleared to 0.
- R6: With `cs_n` low and `rd_n` high throughout a conversion, `bus_oe` stays 0.
- R7: With `cs_n` and `rd_n` held low across a conversion, `bus_out` shows the previous result until `int_n` falls, and the new result from then on.
- R8: With `cs_n` low, `rd_n` low and `fn_dac`=0, `bus_oe` is 1 and `bus_out` carries the output latch. The rising edge of `rd_n` in that state, or the start of a new conversion, returns `int_n` to 1.
- R9: With `cs_n` low, `fn_dac`=1 and `xfer_adc`=1, the rising edge of `wr_n` loads the ADC output latch, not `bus_in`, into the addressed DAC register.
- R10: A conversion `wr_n` that arrives while a conversion is running is ignored. The running conversion keeps its channel and finishes at its original time. The output latch does not change before that conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| fn_dac | input | 1 | Function select: 0 = ADC, 1 = DAC |
| ch_b | input | 1 | Channel select: 0 = A, 1 = B |
| xfer_adc | input | 1 | On a DAC write, take the data from the ADC latch |
| bus_in | input | 8 | Data bus, host to block |
| bus_out | output | 8 | Data bus, block to host |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| int_n | output | 1 | Conversion complete flag, active low |
| hold | output | 1 | Track-and-hold command, 1 = hold |
| in_sel | output | 1 | Input channel being converted: 0 = A, 1 = B |
| trial_code | output | 8 | SAR trial code for the comparator DAC |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `trial_code` |
| dac_a_code | output | 8 | DAC A register |
| dac_b_code | output | 8 | DAC B register |

## Verification
The assertions take for granted that the comparator input follows the current trial code. They also assume that `fn_dac`, `ch_b`, `xfer_adc` and `bus_in` stay steady while a strobe edge passes through the synchronizer, and that `cs_n` stays low for a few clocks on each side of a strobe. Without these, the chip-select and latch checks could see a strobe that was legally sampled but is only half visible. The bench models the comparator as a direct compare of the per-channel input code against `trial_code`. It holds every address and data value at least three clocks before and four clocks after each strobe edge. Its random operations are drawn only from complete, well-formed bus cycles.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int STB_CS = 0;
  localparam int STB_WR = 1;
  localparam int STB_RD = 2;
  localparam int NSTB   = 3;
  localparam int NCH    = 2;
endpackage

// File: rtl/dcp_sync.sv
module dcp_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q    <= '1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcp_sar.sv
module dcp_sar #(
  parameter int DW         = 8,
  parameter int BIT_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_in,
  output logic          busy,
  output logic [DW-1:0] sar,
  output logic          fin,
  output logic [DW-1:0] fin_code
);
  localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          step;

  assign step     = busy && (cnt == CW'(BIT_CYCLES - 1));
  assign fin      = step && (idx == '0);
  assign fin_code = {sar[DW-1:1], cmp_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sar  <= '0;
      cnt  <= '0;
      idx  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      sar  <= {1'b1, {(DW-1){1'b0}}};
      idx  <= IW'(DW - 1);
      cnt  <= '0;
    end else if (busy) begin
      if (step) begin
        cnt <= '0;
        if (idx == '0) begin
          busy <= 1'b0;
          sar  <= '0;
        end else begin
          sar[idx]        <= cmp_in;
          sar[idx - 1'b1] <= 1'b1;
          idx             <= idx - 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcp_dac_bank.sv
module dcp_dac_bank #(
  parameter int DW  = 8,
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [CHW-1:0] ch,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  regs [NCH]
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (ch == CHW'(g)))
        regs[g] <= din;
    end
  end
endmodule

// File: rtl/dual_conv_port.sv
module dual_conv_port #(
  parameter int DW         = 8,
  parameter int BIT_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          fn_dac,
  input  logic          ch_b,
  input  logic          xfer_adc,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          int_n,
  output logic          hold,
  output logic          in_sel,
  output logic [DW-1:0] trial_code,
  input  logic          cmp_in,
  output logic [DW-1:0] dac_a_code,
  output logic [DW-1:0] dac_b_code
);
  import dcp_pkg::*;

  logic [NSTB-1:0] stb_raw, stb_s;
  logic            wr_d, rd_d;
  logic            cs_act, wr_rise, rd_rise, wr_evt;
  logic            conv_start, dac_we, rd_done;
  logic            busy, fin;
  logic [DW-1:0]   sar, fin_code, adc_lat, dac_din;
  logic [DW-1:0]   dac_regs [NCH];

  always_comb begin
    stb_raw         = '1;
    stb_raw[STB_CS] = cs_n;
    stb_raw[STB_WR] = wr_n;
    stb_raw[STB_RD] = rd_n;
  end

  dcp_sync #(.W(NSTB)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(stb_raw), .q(stb_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d <= 1'b1;
      rd_d <= 1'b1;
    end else begin
      wr_d <= stb_s[STB_WR];
      rd_d <= stb_s[STB_RD];
    end
  end

  assign cs_act     = !stb_s[STB_CS];
  assign wr_rise    = stb_s[STB_WR] && !wr_d;
  assign rd_rise    = stb_s[STB_RD] && !rd_d;
  assign wr_evt     = cs_act && wr_rise;
  assign conv_start = wr_evt && !fn_dac && !busy;
  assign dac_we     = wr_evt && fn_dac;
  assign rd_done    = cs_act && rd_rise && !fn_dac;
  assign dac_din    = xfer_adc ? adc_lat : bus_in;

  dcp_sar #(.DW(DW), .BIT_CYCLES(BIT_CYCLES)) u_sar (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .cmp_in(cmp_in),
    .busy(busy), .sar(sar), .fin(fin), .fin_code(fin_code)
  );

  dcp_dac_bank #(.DW(DW), .NCH(NCH)) u_dac (
    .clk(clk), .rst_n(rst_n), .we(dac_we), .ch(ch_b),
    .din(dac_din), .regs(dac_regs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_lat <= '0;
      int_n   <= 1'b1;
      in_sel  <= 1'b0;
    end else begin
      if (fin) begin
        adc_lat <= fin_code;
        int_n   <= 1'b0;
      end else if (conv_start || rd_done) begin
        int_n   <= 1'b1;
      end
      if (conv_start)
        in_sel <= ch_b;
    end
  end

  assign hold       = busy;
  assign trial_code = sar;
  assign bus_oe     = cs_act && !stb_s[STB_RD] && !fn_dac;
  assign bus_out    = adc_lat;
  assign dac_a_code = dac_regs[0];
  assign dac_b_code = dac_regs[1];
endmodule

// File: rtl/dual_conv_port_chk.sv
module dual_conv_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          bus_oe,
  input logic          int_n,
  input logic          hold,
  input logic [DW-1:0] trial_code,
  input logic [DW-1:0] adc_lat
);
  AST_CS_HIGH_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !bus_oe); // R1

  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> (trial_code == {1'b1, {(DW-1){1'b0}}})); // R4

  AST_IDLE_TRIAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (trial_code == '0)); // R5

  AST_INT_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $fell(hold)); // R5

  AST_LATCH_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(adc_lat)); // R10
endmodule

bind dual_conv_port dual_conv_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bus_oe(bus_oe), .int_n(int_n),
  .hold(hold), .trial_code(trial_code), .adc_lat(adc_lat)
);

// File: tb/dual_conv_port_tb.sv
module dual_conv_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BC         = 4;
  localparam int CONV_LEN   = 3 + 8 * BC;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic       fn_dac = 1'b0, ch_b = 1'b0, xfer_adc = 1'b0;
  logic [7:0] bus_in = '0, bus_out, trial_code, dac_a_code, dac_b_code;
  logic       bus_oe, int_n, hold, in_sel, cmp_in;
  logic [7:0] vin_a = '0, vin_b = '0;

  logic [7:0] exp_a = '0, exp_b = '0, exp_lat = '0;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp_in = ((in_sel ? vin_b : vin_a) >= trial_code);

  dual_conv_port #(.DW(8), .BIT_CYCLES(BC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .fn_dac(fn_dac), .ch_b(ch_b), .xfer_adc(xfer_adc), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .int_n(int_n), .hold(hold),
    .in_sel(in_sel), .trial_code(trial_code), .cmp_in(cmp_in),
    .dac_a_code(dac_a_code), .dac_b_code(dac_b_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dac_next(input logic [7:0] cur, input bit hit,
                                          input bit xf, input logic [7:0] d,
                                          input logic [7:0] lat);
    if (!hit) return cur;
    return xf ? lat : d;
  endfunction

  task automatic dac_write(input bit ch, input logic [7:0] v, input bit xf);
    @(negedge clk);
    fn_dac = 1'b1; ch_b = ch; bus_in = v; xfer_adc = xf;
    cs_n = 1'b0; nwait(3);
    wr_n = 1'b0; nwait(3);
    wr_n = 1'b1; nwait(4);
    cs_n = 1'b1; nwait(3);
    xfer_adc = 1'b0;
    exp_a = dac_next(exp_a, !ch, xf, v, exp_lat);
    exp_b = dac_next(exp_b, ch, xf, v, exp_lat);
    chk(dac_a_code == exp_a, xf ? "R9 dac A" : "R3 dac A", dac_a_code, exp_a);
    chk(dac_b_code == exp_b, xf ? "R9 dac B" : "R3 dac B", dac_b_code, exp_b);
  endtask

  task automatic conv_run(input bit ch, input logic [7:0] v, input bit inject);
    int used;
    @(negedge clk);
    if (ch) vin_b = v; else vin_a = v;
    fn_dac = 1'b0; ch_b = ch; cs_n = 1'b0; nwait(3);
    wr_n = 1'b0; nwait(3);
    chk(hold == 1'b0, "R2 no start on falling WR", hold, 0);
    wr_n = 1'b1; nwait(3);
    chk(hold == 1'b1, "R2 hold", hold, 1);
    chk(in_sel == ch, "R2 in_sel", in_sel, ch);
    chk(trial_code == 8'h80, "R4 first trial", trial_code, 8'h80);
    used = 3;
    if (inject) begin
      nwait(5); ch_b = !ch; wr_n = 1'b0; nwait(3);
      wr_n = 1'b1; nwait(4); ch_b = ch;
      used += 12;
      chk(in_sel == ch, "R10 channel kept", in_sel, ch);
    end
    nwait(CONV_LEN - 1 - used);
    chk(int_n == 1'b1 && hold == 1'b1, "R10 still running", {int_n, hold}, 3);
    chk(bus_oe == 1'b0, "R6 bus idle", bus_oe, 0);
    nwait(1);
    exp_lat = v;
    chk(int_n == 1'b0, "R5 int low", int_n, 0);
    chk(hold == 1'b0 && trial_code == 8'h00, "R5 hold/trial clear", {hold, trial_code}, 0);
    cs_n = 1'b1; nwait(3);
  endtask

  task automatic adc_read();
    @(negedge clk);
    fn_dac = 1'b0; cs_n = 1'b0; rd_n = 1'b0; nwait(4);
    chk(bus_oe == 1'b1, "R8 oe", bus_oe, 1);
    chk(bus_out == exp_lat, "R4 R8 result", bus_out, exp_lat);
    rd_n = 1'b1; nwait(4);
    chk(int_n == 1'b1, "R8 int cleared", int_n, 1);
    cs_n = 1'b1; nwait(3);
  endtask

  task automatic held_read_conv(input bit ch, input logic [7:0] v);
    logic [7:0] prev;
    prev = exp_lat;
    @(negedge clk);
    if (ch) vin_b = v; else vin_a = v;
    fn_dac = 1'b0; ch_b = ch; cs_n = 1'b0; rd_n = 1'b0; nwait(4);
    wr_n = 1'b0; nwait(3);
    wr_n = 1'b1; nwait(CONV_LEN - 1);
    chk(bus_oe && bus_out == prev, "R7 previous shown", bus_out, prev);
    nwait(1);
    exp_lat = v;
    chk(int_n == 1'b0 && bus_out == v, "R7 new shown", bus_out, v);
    rd_n = 1'b1; nwait(4);
    chk(int_n == 1'b1, "R8 int cleared on read end", int_n, 1);
    cs_n = 1'b1; nwait(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    nwait(4);
    rst_n = 1'b1;
    nwait(2);
    chk(bus_oe == 0 && int_n == 1 && hold == 0, "R1 reset outputs", {bus_oe, int_n, hold}, 2);
    chk(dac_a_code == 0 && dac_b_code == 0 && trial_code == 0, "R5 reset regs", dac_a_code, 0);

    dac_write(1'b0, 8'h5A, 1'b0);
    dac_write(1'b1, 8'hC3, 1'b0);

    // R1: strobes with CS high do nothing
    @(negedge clk);
    fn_dac = 1'b1; ch_b = 1'b0; bus_in = 8'hFF;
    wr_n = 1'b0; rd_n = 1'b0; nwait(4);
    chk(bus_oe == 1'b0, "R1 no drive", bus_oe, 0);
    wr_n = 1'b1; nwait(4);
    fn_dac = 1'b0; wr_n = 1'b0; nwait(4); wr_n = 1'b1; nwait(5);
    rd_n = 1'b1;
    chk(dac_a_code == exp_a, "R1 dac untouched", dac_a_code, exp_a);
    chk(hold == 1'b0, "R1 no conversion", hold, 0);

    conv_run(1'b0, 8'h00, 1'b0); adc_read();
    conv_run(1'b1, 8'hFF, 1'b0); adc_read();
    conv_run(1'b0, 8'h80, 1'b1); adc_read();
    conv_run(1'b1, 8'h7F, 1'b0);
    dac_write(1'b0, 8'h11, 1'b1);
    held_read_conv(1'b0, 8'h3C);
    dac_write(1'b1, 8'h22, 1'b1);

    for (int i = 0; i < 24; i++) begin
      int op;
      op = $urandom % 3;
      case (op)
        0: dac_write(1'($urandom), 8'($urandom), 1'b0);
        1: begin conv_run(1'($urandom), 8'($urandom), 1'($urandom)); adc_read(); end
        default: dac_write(1'($urandom), 8'($urandom), 1'b1);
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule